// File: doc/BRIEF.md
# Effective Vector Length Resolver

This block keeps the vector-length control word for the hypervisor privilege level. It turns the word into the vector length that the hardware actually uses. Software writes a 4-bit length request through a simple write port. A direct read returns the stored request unchanged. The resolver combines the request with two things: an optional cap from the next higher privilege level, and the set of lengths that the implementation supports. It reports the result both as a count of 128-bit granules and as a width in bits.

The resolution runs in a fixed order. First, when the higher level is present and the requested length is above that level's effective length, the request is lowered to the higher level's length. Second, the value is rounded down to the largest supported length. The supported lengths are every power of two from one granule up to the configured maximum. When streaming mode is active, the control word has no effect, and a separately supplied streaming length is passed to the outputs. The outputs are registered. A write shows up in them one clock later, with no extra synchronisation step.

Top module: `evl_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, the stored request takes the parameter `RST_LEN`. The outputs `eff_gran` and `eff_bits` take 1 granule and 128 bits.
- R2: `rd_data` holds the stored 4-bit request in bits 3:0. Bits 63:4 always read as zero, whatever was written to them.
- R3: With no cap and no streaming, the requested length is (request + 1) granules. `eff_gran` is the largest power of two not above that length, limited to `MAX_BITS/128` granules.
- R4: When `cap_present` is high and request + 1 is greater than `cap_len` + 1, the value `cap_len` + 1 replaces the requested length before rounding. Otherwise the request is kept.
- R5: When `cap_present` is low, `cap_len` has no effect on the outputs.
- R6: When `strm_active` is high, `eff_gran` becomes `strm_len` + 1. The stored request and the cap have no effect on the outputs.
- R7: The outputs change at the rising edge that samples their inputs. After the edge that accepts a write, they already reflect the new request.
- R8: `eff_bits` always equals `eff_gran` × 128.
- R9: The stored request changes only at an edge where `wr_en` is high. `wr_data` is ignored at all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Write data; only bits 3:0 are stored |
| rd_data | output | 64 | Direct read of the control word |
| cap_present | input | 1 | Higher privilege level exists |
| cap_len | input | 4 | Higher level's effective length, granules minus one |
| strm_active | input | 1 | Streaming mode active |
| strm_len | input | 4 | Streaming effective length, granules minus one |
| eff_gran | output | 5 | Effective length in 128-bit granules |
| eff_bits | output | 12 | Effective length in bits |

## Verification
The clocked properties assume that all inputs carry known values at every rising edge after reset. They also assume that `cap_len` and `strm_len` arrive already encoded as granules minus one. The bench drives every input on the falling edge and never lets an input float. It sweeps every request against every cap value, with the cap both enabled and disabled, and every streaming length. It uses a 1024-bit maximum, so that both the maximum limit and the non-power-of-two rounding are exercised.

// File: rtl/evl_pkg.sv
package evl_pkg;

  // number of granules that fit into a width in bits
  function automatic int unsigned gran_count(input int unsigned bits,
                                             input int unsigned gran_bits);
    return bits / gran_bits;
  endfunction

  // ceiling log2, used for widths and shift amounts
  function automatic int unsigned clog2u(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/evl_ctrl_reg.sv
module evl_ctrl_reg #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned RST_LEN = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LEN_W-1:0]  req_q,
  output logic [LEN_W-1:0]  req_nxt,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - LEN_W;

  // upper bits are read-as-zero and write-ignored
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:LEN_W];

  // forward the incoming write so the resolver sees it at once
  assign req_nxt = wr_en ? wr_data[LEN_W-1:0] : req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= LEN_W'(RST_LEN);
    else     req_q <= req_nxt;
  end

  assign rd_data = {{PAD_W{1'b0}}, req_q};

  // R9: without a write strobe the stored request must not move
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(req_q));

  // R2: a write lands in the read port one edge later
  a_r2_read_back: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[LEN_W-1:0] == $past(wr_data[LEN_W-1:0]));

endmodule

// File: rtl/evl_clamp.sv
module evl_clamp #(
  parameter int unsigned LEN_W = 4,
  localparam int unsigned GW   = LEN_W + 1
) (
  input  logic [LEN_W-1:0] req,
  input  logic             cap_present,
  input  logic [LEN_W-1:0] cap_len,
  output logic [GW-1:0]    gran
);
  logic [GW-1:0] req_g;
  logic [GW-1:0] cap_g;

  assign req_g = {1'b0, req} + GW'(1);
  assign cap_g = {1'b0, cap_len} + GW'(1);

  // the higher level wins only when it is present and smaller
  always_comb begin
    if (cap_present && (req_g > cap_g)) gran = cap_g;
    else                                gran = req_g;
  end
endmodule

// File: rtl/evl_round.sv
module evl_round #(
  parameter int unsigned GW       = 5,
  parameter int unsigned MAX_GRAN = 16
) (
  input  logic [GW-1:0] gran_in,
  output logic [GW-1:0] gran_out
);
  localparam int unsigned NLVL = evl_pkg::clog2u(MAX_GRAN) + 1;

  logic [NLVL-1:0] reach;

  // one comparator per supported power-of-two length
  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    assign reach[i] = gran_in >= GW'(1 << i);
  end

  // the highest supported length reached wins
  always_comb begin
    gran_out = GW'(1);
    for (int i = 0; i < NLVL; i++) begin
      if (reach[i]) gran_out = GW'(1) << i;
    end
  end
endmodule

// File: rtl/evl_resolver.sv
module evl_resolver #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned GRAN_BITS = 128,
  parameter int unsigned MAX_BITS  = 2048,
  parameter int unsigned RST_LEN   = 0,
  localparam int unsigned GW       = LEN_W + 1,
  localparam int unsigned BITS_W   = evl_pkg::clog2u((1 << LEN_W) * GRAN_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cap_present,
  input  logic [LEN_W-1:0]  cap_len,
  input  logic              strm_active,
  input  logic [LEN_W-1:0]  strm_len,
  output logic [GW-1:0]     eff_gran,
  output logic [BITS_W-1:0] eff_bits
);
  localparam int unsigned MAX_GRAN = evl_pkg::gran_count(MAX_BITS, GRAN_BITS);
  localparam int unsigned GSH      = evl_pkg::clog2u(GRAN_BITS);

  logic [LEN_W-1:0] req_q;
  logic [LEN_W-1:0] req_nxt;
  logic [GW-1:0]    clamped;
  logic [GW-1:0]    rounded;
  logic [GW-1:0]    sel_gran;

  evl_ctrl_reg #(.DATA_W(DATA_W), .LEN_W(LEN_W), .RST_LEN(RST_LEN)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .req_q(req_q), .req_nxt(req_nxt), .rd_data(rd_data)
  );

  evl_clamp #(.LEN_W(LEN_W)) u_clamp (
    .req(req_nxt), .cap_present(cap_present), .cap_len(cap_len), .gran(clamped)
  );

  evl_round #(.GW(GW), .MAX_GRAN(MAX_GRAN)) u_round (
    .gran_in(clamped), .gran_out(rounded)
  );

  // streaming mode bypasses the control word entirely
  assign sel_gran = strm_active ? ({1'b0, strm_len} + GW'(1)) : rounded;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_gran <= GW'(1);
      eff_bits <= BITS_W'(GRAN_BITS);
    end else begin
      eff_gran <= sel_gran;
      eff_bits <= BITS_W'(sel_gran) << GSH;
    end
  end

  // R3: outside streaming the result is a single supported power of two
  a_r3_power_of_two: assert property (@(posedge clk) disable iff (rst)
    !strm_active |=> $onehot(eff_gran));

  a_r3_within_max: assert property (@(posedge clk) disable iff (rst)
    !strm_active |=> eff_gran <= GW'(MAX_GRAN));

  // R4: an active cap bounds the result
  a_r4_cap_bound: assert property (@(posedge clk) disable iff (rst)
    (cap_present && !strm_active) |=> eff_gran <= ({1'b0, $past(cap_len)} + GW'(1)));

  // R6: streaming length passes straight through
  a_r6_stream_pass: assert property (@(posedge clk) disable iff (rst)
    strm_active |=> eff_gran == ({1'b0, $past(strm_len)} + GW'(1)));

  // R7: a write bounds the result already at the next cycle
  a_r7_write_visible: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !strm_active) |=> eff_gran <= ({1'b0, $past(wr_data[LEN_W-1:0])} + GW'(1)));

endmodule

// File: tb/evl_resolver_test.sv
module evl_resolver_test;
  localparam int unsigned MAXB  = 1024;
  localparam int unsigned MAXG  = MAXB / 128;
  localparam int unsigned RSTL  = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic        cap_present;
  logic [3:0]  cap_len;
  logic        strm_active;
  logic [3:0]  strm_len;
  logic [4:0]  eff_gran;
  logic [11:0] eff_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evl_resolver #(.MAX_BITS(MAXB), .RST_LEN(RSTL)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cap_present(cap_present), .cap_len(cap_len), .strm_active(strm_active),
    .strm_len(strm_len), .eff_gran(eff_gran), .eff_bits(eff_bits)
  );

  function automatic int model(int r, bit cp, int c);
    int g;
    int p;
    g = r + 1;
    if (cp && g > c + 1) g = c + 1;
    if (g > MAXG) g = MAXG;
    p = 1;
    while (p * 2 <= g) p = p * 2;
    return p;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_eff(string req, int exp);
    check(req, eff_gran, exp);
    check({req, "/R8"}, eff_bits, exp * 128);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    cap_present = 1'b0; cap_len = '0; strm_active = 1'b0; strm_len = '0;
    step; step;
    check("R1 rd", rd_data, RSTL);
    check_eff("R1 eff", 1);
    rst = 1'b0;
    step;
    check_eff("R3 reset request", model(RSTL, 0, 0));

    for (int r = 0; r < 16; r++) begin
      // write with junk in the upper bits
      wr_en = 1'b1; wr_data = 64'hA5A5_F00D_CAFE_BEE0 | 64'(r);
      cap_present = 1'b0; cap_len = 4'd0;
      step;
      wr_en = 1'b0;
      check("R2 rd", rd_data, r);
      check_eff("R7 write next cycle", model(r, 0, 0));
      // R9: data without strobe is ignored
      wr_data = 64'(15 - r);
      step;
      check("R9 no strobe", rd_data, r);
      check_eff("R3 plain", model(r, 0, 0));
      for (int c = 0; c < 16; c++) begin
        cap_present = 1'b1; cap_len = 4'(c);
        step;
        check_eff("R4 cap", model(r, 1, c));
        cap_present = 1'b0;
        step;
        check_eff("R5 cap ignored", model(r, 0, 0));
      end
    end

    for (int s = 0; s < 16; s++) begin
      strm_active = 1'b1; strm_len = 4'(s);
      cap_present = 1'b1; cap_len = 4'd0;
      wr_en = 1'b1; wr_data = 64'(s ^ 9);
      step;
      wr_en = 1'b0;
      check_eff("R6 streaming", s + 1);
      check("R6 rd still written", rd_data, s ^ 9);
      strm_active = 1'b0; cap_present = 1'b0;
      step;
      check_eff("R6 leave streaming", model(s ^ 9, 0, 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule